// File: doc/BRIEF.md
# Adaptive Dead-Time Gate Sequencer

This block turns a PWM command into the two switch enables of a half-bridge, a high-side enable and a low-side enable. It never turns on one switch until feedback shows that the other switch is really off. The PWM command arrives already split into three one-hot level flags: high, low and mid. Three digital feedback flags come from comparators outside the block: low-side gate discharged, switch node fallen, and high-side gate discharged. A fixed number of clock cycles, set by a parameter, is counted after the relevant flag is seen before the opposite switch may turn on.

On a high-to-low change, the switch-node flag may never arrive. For that case a second, longer timer starts from the high-side-gate-discharged flag and turns the low side on anyway. If the PWM input rests at the mid level long enough, both switches are released (three-state). Leaving that condition goes straight to the commanded switch. An active-low skip input holds the low side off for as long as it stays low.

Top module: `adt_gate_seq`

## Requirements
- R1: `hs_en` and `ls_en` are never high in the same cycle.
- R2: When `pwm_hi` arrives while the low side is on, `ls_en` falls at the next clock edge. If the first edge that samples `ls_gate_low` high during the wait is edge k, then `hs_en` rises at edge k+DEAD_ON.
- R3: When `pwm_lo` arrives while the high side is on, `hs_en` falls at the next clock edge. If the first edge that samples `sw_fell` high during the wait is edge k, then `ls_en` rises at edge k+DEAD_OFF.
- R4: During the high-to-low wait, the first edge k that samples `hs_gate_low` high starts a backup timer. `ls_en` rises at edge k+TIMEOUT even if `sw_fell` never asserts.
- R5: `ls_en` rises at whichever completes first, the switch-node path or the backup timer. Completion of the slower path afterwards changes neither enable.
- R6: `pwm_mid` held for HOLDOFF consecutive cycles drops both enables at the edge that closes the HOLDOFF-th cycle. A shorter mid stretch keeps the previous command and leaves the enables unchanged.
- R7: From the three-state condition, `pwm_hi` raises `hs_en` at the next edge and `pwm_lo` raises `ls_en` at the next edge. Neither exit waits for any feedback flag.
- R8: `skip_n` low forces `ls_en` low in the same cycle. `skip_n` high restores `ls_en` in the same cycle while the low-side phase is held.
- R9: If the PWM command reverses before a pending turn-on completes, that turn-on never happens. Both enables stay low, and the new direction's wait and delay run from the start.
- R10: `rst` sampled high makes both enables low in the next cycle. Both stay low until the first `pwm_hi` or `pwm_lo` after reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| pwm_hi | input | 1 | PWM command at the high level (one-hot with pwm_lo, pwm_mid) |
| pwm_lo | input | 1 | PWM command at the low level |
| pwm_mid | input | 1 | PWM command at the mid (three-state) level |
| ls_gate_low | input | 1 | Low-side gate has discharged |
| sw_fell | input | 1 | Switch node has fallen below its threshold |
| hs_gate_low | input | 1 | High-side gate has discharged |
| skip_n | input | 1 | Low forces the low-side enable off |
| hs_en | output | 1 | High-side switch enable |
| ls_en | output | 1 | Low-side switch enable |

## Verification
- A PWM level, an exit from three-state, or a reset shows on the enables one cycle after the edge that samples it.
- A feedback flag set during cycle j starts its delay at edge j+1. The resulting turn-on is therefore due DEAD_ON, DEAD_OFF or TIMEOUT cycles after that, and three-state takes effect HOLDOFF cycles after mid first appears.
- Skip acts within the cycle it changes.
- The bench converts each of these latencies into an absolute cycle number when it applies the stimulus. It checks the enables in that cycle, and also one cycle earlier to show that nothing arrives early.

// File: rtl/adt_pkg.sv
package adt_pkg;

  typedef enum logic [2:0] {
    ST_OFF,       // both released: reset idle or three-state
    ST_HS_ON,
    ST_LS_ON,
    ST_WAIT_LS,   // heading high, low-side gate not yet seen discharged
    ST_DEAD_ON,   // heading high, counting the turn-on gap
    ST_WAIT_SW,   // heading low, switch node not yet seen fallen
    ST_DEAD_OFF   // heading low, counting the turn-on gap
  } seq_state_t;

  function automatic logic in_rise_path(seq_state_t s);
    return (s == ST_WAIT_LS) || (s == ST_DEAD_ON);
  endfunction

  function automatic logic in_fall_path(seq_state_t s);
    return (s == ST_WAIT_SW) || (s == ST_DEAD_OFF);
  endfunction

  // counter width able to hold n-1
  function automatic int unsigned cnt_width(int unsigned n);
    return (n > 1) ? $clog2(n) : 1;
  endfunction

endpackage

// File: rtl/adt_delay_timer.sv
module adt_delay_timer #(
  parameter int unsigned LEN = 4
) (
  input  logic clk,
  input  logic rst,
  input  logic clr,
  input  logic start,
  output logic done
);
  localparam int unsigned CW = adt_pkg::cnt_width(LEN);
  localparam logic [CW-1:0] LAST = CW'(LEN - 1);

  logic          run;
  logic [CW-1:0] cnt;

  // start sampled at edge e -> done seen during the cycle before edge e+LEN
  always_ff @(posedge clk) begin
    if (rst || clr) begin
      run <= 1'b0;
      cnt <= '0;
    end else if (!run && start) begin
      run <= 1'b1;
      cnt <= '0;
    end else if (run && !done) begin
      cnt <= cnt + CW'(1);
    end
  end

  assign done = run && (cnt == LAST);
endmodule

// File: rtl/adt_mid_watch.sv
module adt_mid_watch #(
  parameter int unsigned HOLD = 8
) (
  input  logic clk,
  input  logic rst,
  input  logic mid,
  output logic trip
);
  localparam int unsigned CW = adt_pkg::cnt_width(HOLD);
  localparam logic [CW-1:0] LAST = CW'(HOLD - 1);

  logic [CW-1:0] run_len;

  // counts consecutive mid cycles, saturating at HOLD-1
  always_ff @(posedge clk) begin
    if (rst || !mid)       run_len <= '0;
    else if (run_len != LAST) run_len <= run_len + CW'(1);
  end

  assign trip = mid && (run_len == LAST);
endmodule

// File: rtl/adt_gate_seq.sv
module adt_gate_seq #(
  parameter int unsigned DEAD_ON  = 4,
  parameter int unsigned DEAD_OFF = 6,
  parameter int unsigned TIMEOUT  = 12,
  parameter int unsigned HOLDOFF  = 8
) (
  input  logic clk,
  input  logic rst,
  input  logic pwm_hi,
  input  logic pwm_lo,
  input  logic pwm_mid,
  input  logic ls_gate_low,
  input  logic sw_fell,
  input  logic hs_gate_low,
  input  logic skip_n,
  output logic hs_en,
  output logic ls_en
);
  import adt_pkg::*;

  if (TIMEOUT <= DEAD_OFF || DEAD_ON == 0 || DEAD_OFF == 0 || HOLDOFF == 0) begin : g_cfg_bad
    $error("adt_gate_seq: delays must be nonzero and TIMEOUT must exceed DEAD_OFF");
  end

  seq_state_t st, st_nx;

  logic on_raw, off_raw, to_raw;
  logic rise_clr, fall_clr;

  // named events shared with the checker
  logic ev_on_done, ev_off_done, ev_to_done;
  logic ev_exit_hi, ev_exit_lo, ev_tri;

  assign rise_clr = !in_rise_path(st);
  assign fall_clr = !in_fall_path(st);

  adt_delay_timer #(.LEN(DEAD_ON)) u_dead_on (
    .clk(clk), .rst(rst), .clr(rise_clr),
    .start(st == ST_WAIT_LS && ls_gate_low), .done(on_raw)
  );

  adt_delay_timer #(.LEN(DEAD_OFF)) u_dead_off (
    .clk(clk), .rst(rst), .clr(fall_clr),
    .start(st == ST_WAIT_SW && sw_fell), .done(off_raw)
  );

  adt_delay_timer #(.LEN(TIMEOUT)) u_backup (
    .clk(clk), .rst(rst), .clr(fall_clr),
    .start(in_fall_path(st) && hs_gate_low), .done(to_raw)
  );

  adt_mid_watch #(.HOLD(HOLDOFF)) u_mid (
    .clk(clk), .rst(rst), .mid(pwm_mid), .trip(ev_tri)
  );

  assign ev_on_done  = on_raw  && (st == ST_DEAD_ON);
  assign ev_off_done = off_raw && (st == ST_DEAD_OFF);
  assign ev_to_done  = to_raw  && in_fall_path(st);
  assign ev_exit_hi  = (st == ST_OFF) && pwm_hi;
  assign ev_exit_lo  = (st == ST_OFF) && pwm_lo && !pwm_hi;

  always_comb begin
    st_nx = st;
    unique case (st)
      ST_OFF: begin
        if (ev_exit_hi)      st_nx = ST_HS_ON;
        else if (ev_exit_lo) st_nx = ST_LS_ON;
      end
      ST_HS_ON: begin
        if (ev_tri)      st_nx = ST_OFF;
        else if (pwm_lo) st_nx = ST_WAIT_SW;
      end
      ST_LS_ON: begin
        if (ev_tri)      st_nx = ST_OFF;
        else if (pwm_hi) st_nx = ST_WAIT_LS;
      end
      ST_WAIT_LS: begin
        if (ev_tri)           st_nx = ST_OFF;
        else if (pwm_lo)      st_nx = ST_WAIT_SW;
        else if (ls_gate_low) st_nx = ST_DEAD_ON;
      end
      ST_DEAD_ON: begin
        if (ev_tri)          st_nx = ST_OFF;
        else if (pwm_lo)     st_nx = ST_WAIT_SW;
        else if (ev_on_done) st_nx = ST_HS_ON;
      end
      ST_WAIT_SW: begin
        if (ev_tri)          st_nx = ST_OFF;
        else if (pwm_hi)     st_nx = ST_WAIT_LS;
        else if (ev_to_done) st_nx = ST_LS_ON;
        else if (sw_fell)    st_nx = ST_DEAD_OFF;
      end
      ST_DEAD_OFF: begin
        if (ev_tri)                          st_nx = ST_OFF;
        else if (pwm_hi)                     st_nx = ST_WAIT_LS;
        else if (ev_off_done || ev_to_done)  st_nx = ST_LS_ON;
      end
      default: st_nx = ST_OFF;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) st <= ST_OFF;
    else     st <= st_nx;
  end

  assign hs_en = (st == ST_HS_ON);
  assign ls_en = (st == ST_LS_ON) && skip_n;
endmodule

// File: rtl/adt_gate_seq_chk.sv
module adt_gate_seq_chk (
  input logic clk,
  input logic rst,
  input logic pwm_lo,
  input logic skip_n,
  input logic hs_en,
  input logic ls_en,
  input logic ev_on_done,
  input logic ev_off_done,
  input logic ev_to_done,
  input logic ev_exit_hi,
  input logic ev_exit_lo,
  input logic ev_tri
);
  logic rst_q;
  always_ff @(posedge clk) rst_q <= rst;

  AST_NO_OVERLAP: assert property (@(posedge clk) disable iff (rst)
    !(hs_en && ls_en));  // R1

  AST_HS_ON_CAUSE: assert property (@(posedge clk) disable iff (rst)
    $rose(hs_en) |-> $past(ev_on_done || ev_exit_hi));  // R2

  AST_LS_ON_CAUSE: assert property (@(posedge clk) disable iff (rst)
    ($rose(ls_en) && $past(skip_n)) |-> $past(ev_off_done || ev_to_done || ev_exit_lo));  // R3

  AST_BACKUP_FIRES: assert property (@(posedge clk) disable iff (rst)
    (ev_to_done && pwm_lo) |=> (ls_en || !skip_n));  // R4

  AST_TRI_DROP: assert property (@(posedge clk) disable iff (rst)
    ev_tri |=> (!hs_en && !ls_en));  // R6

  AST_SKIP_MASK: assert property (@(posedge clk) disable iff (rst)
    !skip_n |-> !ls_en);  // R8

  AST_REVERSE_ABORT: assert property (@(posedge clk) disable iff (rst)
    (!hs_en && pwm_lo) |=> !hs_en);  // R9

  always @(negedge clk) begin
    if (rst_q) begin
      AST_RST_IDLE: assert (!hs_en && !ls_en);  // R10
    end
  end
endmodule

bind adt_gate_seq adt_gate_seq_chk u_chk (
  .clk(clk), .rst(rst), .pwm_lo(pwm_lo), .skip_n(skip_n),
  .hs_en(hs_en), .ls_en(ls_en),
  .ev_on_done(ev_on_done), .ev_off_done(ev_off_done), .ev_to_done(ev_to_done),
  .ev_exit_hi(ev_exit_hi), .ev_exit_lo(ev_exit_lo), .ev_tri(ev_tri)
);

// File: tb/adt_gate_seq_test.sv
module adt_gate_seq_test;
  localparam int P_ON = 3, P_OFF = 4, P_TO = 7, P_HOLD = 5;
  localparam int LO = 0, HI = 1, MID = 2;

  logic clk = 1'b0, rst = 1'b1;
  logic pwm_hi = 1'b0, pwm_lo = 1'b0, pwm_mid = 1'b1;
  logic ls_gate_low = 1'b0, sw_fell = 1'b0, hs_gate_low = 1'b0, skip_n = 1'b1;
  logic hs_en, ls_en;

  adt_gate_seq #(.DEAD_ON(P_ON), .DEAD_OFF(P_OFF), .TIMEOUT(P_TO), .HOLDOFF(P_HOLD)) uut (
    .clk(clk), .rst(rst), .pwm_hi(pwm_hi), .pwm_lo(pwm_lo), .pwm_mid(pwm_mid),
    .ls_gate_low(ls_gate_low), .sw_fell(sw_fell), .hs_gate_low(hs_gate_low),
    .skip_n(skip_n), .hs_en(hs_en), .ls_en(ls_en)
  );

  always #5 clk = ~clk;

  int cyc = 0;
  always @(posedge clk) cyc++;

  // scoreboard: expected enables keyed by absolute cycle
  int    q_at[$];
  bit    q_hs[$];
  bit    q_ls[$];
  string q_req[$];
  int total = 0, bad = 0;
  bit finished = 1'b0;

  task automatic expect_at(input int off, input bit hs, input bit ls, input string req);
    int at = cyc + off;
    int i = 0;
    while (i < q_at.size() && q_at[i] <= at) i++;
    q_at.insert(i, at);
    q_hs.insert(i, hs);
    q_ls.insert(i, ls);
    q_req.insert(i, req);
  endtask

  always @(negedge clk) begin
    int    e_at;
    bit    e_hs, e_ls;
    string e_req;
    if (!rst) begin
      total++;
      if (hs_en && ls_en) begin
        bad++;
        $display("FAIL R1 cyc=%0d: actual hs=1 ls=1 expected not both high", cyc);
      end
    end
    while (q_at.size() > 0 && q_at[0] <= cyc) begin
      e_at = q_at.pop_front();
      e_hs = q_hs.pop_front();
      e_ls = q_ls.pop_front();
      e_req = q_req.pop_front();
      total++;
      if (e_at != cyc || hs_en !== e_hs || ls_en !== e_ls) begin
        bad++;
        $display("FAIL %s cyc=%0d (due %0d): actual hs=%b ls=%b expected hs=%b ls=%b",
                 e_req, cyc, e_at, hs_en, ls_en, e_hs, e_ls);
      end
    end
  end

  task automatic tick(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic drain();
    while (q_at.size() != 0) @(negedge clk);
    tick(1);
  endtask

  task automatic set_pwm(input int lvl);
    pwm_lo  = (lvl == LO);
    pwm_hi  = (lvl == HI);
    pwm_mid = (lvl == MID);
  endtask

  task automatic summary();
    $display("test done: total=%0d bad=%0d", total, bad);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      total++;
      bad++;
      $display("FAIL watchdog: actual=still running expected=completed");
      summary();
      $finish;
    end
  end

  initial begin
    // R10: reset state, then idle while mid
    tick(2);
    expect_at(0, 0, 0, "R10");
    drain();
    rst = 1'b0;
    expect_at(P_HOLD + 2, 0, 0, "R10");
    drain();
    // R10/R7: first low level goes straight to low side
    set_pwm(LO);
    expect_at(0, 0, 0, "R10");
    expect_at(1, 0, 1, "R10");
    drain();

    // R2: rising edge, waiting for low-side discharge
    set_pwm(HI);
    expect_at(1, 0, 0, "R2");
    expect_at(4, 0, 0, "R2");
    drain();
    ls_gate_low = 1'b1;
    expect_at(P_ON, 0, 0, "R2");
    expect_at(P_ON + 1, 1, 0, "R2");
    drain();

    // R3/R5: falling edge, switch-node path wins
    ls_gate_low = 1'b0;
    set_pwm(LO);
    expect_at(1, 0, 0, "R3");
    expect_at(3, 0, 0, "R3");
    drain();
    sw_fell = 1'b1;
    hs_gate_low = 1'b1;
    expect_at(P_OFF, 0, 0, "R3");
    expect_at(P_OFF + 1, 0, 1, "R3");
    expect_at(P_TO + 4, 0, 1, "R5");
    drain();

    // R2: discharge flag already present
    sw_fell = 1'b0;
    hs_gate_low = 1'b0;
    ls_gate_low = 1'b1;
    set_pwm(HI);
    expect_at(1, 0, 0, "R2");
    expect_at(P_ON + 1, 0, 0, "R2");
    expect_at(P_ON + 2, 1, 0, "R2");
    drain();

    // R4: backup timer only
    ls_gate_low = 1'b0;
    hs_gate_low = 1'b1;
    set_pwm(LO);
    expect_at(1, 0, 0, "R3");
    expect_at(P_TO + 1, 0, 0, "R4");
    expect_at(P_TO + 2, 0, 1, "R4");
    drain();

    // R5: backup timer beats a late switch-node flag
    hs_gate_low = 1'b0;
    ls_gate_low = 1'b1;
    set_pwm(HI);
    expect_at(P_ON + 2, 1, 0, "R2");
    drain();
    ls_gate_low = 1'b0;
    hs_gate_low = 1'b1;
    set_pwm(LO);
    expect_at(P_TO + 1, 0, 0, "R5");
    expect_at(P_TO + 2, 0, 1, "R5");
    expect_at(P_TO + 6, 0, 1, "R5");
    tick(5);
    sw_fell = 1'b1;
    drain();

    // R9: reversal in the middle of the dead-on count
    sw_fell = 1'b0;
    hs_gate_low = 1'b0;
    ls_gate_low = 1'b1;
    set_pwm(HI);
    expect_at(1, 0, 0, "R9");
    expect_at(5, 0, 0, "R9");
    expect_at(6, 0, 0, "R9");
    tick(3);
    set_pwm(LO);
    hs_gate_low = 1'b1;
    ls_gate_low = 1'b0;
    expect_at(8, 0, 0, "R9");
    expect_at(9, 0, 1, "R9");
    drain();

    // R8: skip masks and restores the low side
    skip_n = 1'b0;
    expect_at(0, 0, 0, "R8");
    expect_at(3, 0, 0, "R8");
    drain();
    skip_n = 1'b1;
    expect_at(0, 0, 1, "R8");
    drain();

    // R6: short mid stretch is ignored
    set_pwm(MID);
    expect_at(2, 0, 1, "R6");
    expect_at(3, 0, 1, "R6");
    tick(4);
    set_pwm(LO);
    expect_at(2, 0, 1, "R6");
    drain();

    // R6: long mid enters three-state; R7: exit high without feedback
    set_pwm(MID);
    expect_at(P_HOLD - 1, 0, 1, "R6");
    expect_at(P_HOLD, 0, 0, "R6");
    expect_at(P_HOLD + 4, 0, 0, "R6");
    drain();
    hs_gate_low = 1'b0;
    set_pwm(HI);
    expect_at(1, 1, 0, "R7");
    drain();
    set_pwm(MID);
    expect_at(P_HOLD - 1, 1, 0, "R6");
    expect_at(P_HOLD, 0, 0, "R6");
    drain();
    set_pwm(LO);
    expect_at(1, 0, 1, "R7");
    drain();

    // R10: reset during operation
    rst = 1'b1;
    expect_at(1, 0, 0, "R10");
    expect_at(2, 0, 0, "R10");
    drain();
    rst = 1'b0;
    expect_at(1, 0, 1, "R10");
    drain();

    finished = 1'b1;
    summary();
    $finish;
  end
endmodule